// File: doc/BRIEF.md
# I2C Bit-Level Byte Engine

This block is the lowest layer of an I2C controller. A higher-level sequencer hands it one bus primitive at a time: a start condition, a stop condition, a byte to transmit, or a byte to receive together with the acknowledge level to return. The engine drives the clock and data lines through the whole primitive. It returns the sampled acknowledge after a transmitted byte and the assembled byte after a received one.

Timing is built from a delay unit of `QUARTER` clock cycles. Every primitive is a fixed list of line changes, and each change is followed by a whole number of units. Transmitted bits change data while the clock is low and then hold the clock high for two units. Received bits are sampled one unit into the clock-high half. Both lines are open-drain: a 1 on `sda_o` or `scl_o` means the line is released.

Top module: `i2c_byte_phy`

## Requirements
- R1: After reset, `ready` is 1, `scl_o` and `sda_o` are 1 (released), `ack_n` is 1 and `rx_data` is 0.
- R2: A command is taken only on a cycle with `cmd_valid` and `ready` both high, using the encoding `cmd_op` 00 = start, 01 = stop, 10 = write byte, 11 = read byte. `ready` then stays low for exactly U x `QUARTER` cycles, where U is 4 for start and stop, 37 for write and 29 for read. While `ready` is low, `cmd_valid` has no effect.
- R3: A start produces exactly one falling edge of `sda_o` while `scl_o` is high, and no rising data edge while the clock is high. It ends with `scl_o` = 1 and `sda_o` = 0.
- R4: A stop raises `sda_o` while `scl_o` is high. Before that edge, the clock was driven low and then data was driven low. It ends with both lines at 1.
- R5: A write shifts `cmd_data` out MSB first on eight clock pulses. `sda_o` never changes while `scl_o` stays high. On the ninth pulse `sda_o` is released (1).
- R6: After a write, `ack_n` holds the `sda_i` level sampled during the ninth clock-high phase (0 = acknowledged, 1 = not acknowledged).
- R7: A read keeps `sda_o` released for eight clock pulses and assembles `rx_data` from `sda_i`, MSB first.
- R8: On the ninth pulse of a read, `sda_o` equals `cmd_nack` as captured when the command was taken (0 drives an acknowledge, 1 leaves the line high).
- R9: `ack_n` is changed only by writes and `rx_data` only by reads. Both keep their values while the engine is idle until the next command is taken, whatever `sda_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (00 start, 01 stop, 10 write, 11 read) |
| cmd_data | input | 8 | Byte to transmit |
| cmd_nack | input | 1 | Acknowledge level to return after a read |
| ready | output | 1 | High when a command can be taken |
| ack_n | output | 1 | Acknowledge level seen after the last write |
| rx_data | output | 8 | Byte assembled by the last read |
| scl_o | output | 1 | Clock line drive (1 = released) |
| sda_o | output | 1 | Data line drive (1 = released) |
| sda_i | input | 1 | Data line level as seen on the bus |

## Verification
The hardest case to reach from the ports is a target that drives the data line only while the clock is low, so that the engine's sample point falls inside a window where a value changed by the target is stable. The bench models a target that counts clock rises and changes its own open-drain output only on cycles where it observes the clock low. It is wired-AND with the engine's drive. The same stream of commands covers repeated starts, reads ending with both acknowledge levels, and acknowledged and refused writes. This lets each sample land where the engine's schedule puts it.

// File: rtl/i2c_byte_phy.sv
module i2c_byte_phy #(
  parameter int QUARTER = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_nack,
  output logic       ready,
  output logic       ack_n,
  output logic [7:0] rx_data,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);

  localparam int TW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

  typedef enum logic [2:0] {IDLE, STA, STO, WBIT, WACK, RBIT, RACK} ph_t;

  ph_t         ph, tph;
  logic [2:0]  unit, tu, last_u, bitn;
  logic [TW-1:0] tick;
  logic [7:0]  sh;
  logic        nack_q, busy, accept, step, fire;

  assign busy   = (ph != IDLE);
  assign ready  = !busy;
  assign accept = cmd_valid && ready;
  assign step   = busy && (tick == '0);
  assign fire   = accept || step;

  always_comb begin
    case (ph)
      STA, STO, WBIT: last_u = 3'd3;
      WACK, RACK:     last_u = 3'd4;
      RBIT:           last_u = 3'd2;
      default:        last_u = 3'd0;
    endcase
  end

  always_comb begin
    tph = ph;
    tu  = unit + 3'd1;
    if (accept) begin
      tu = 3'd0;
      case (cmd_op)
        2'd0:    tph = STA;
        2'd1:    tph = STO;
        2'd2:    tph = WBIT;
        default: tph = RBIT;
      endcase
    end else if (unit == last_u) begin
      tu = 3'd0;
      case (ph)
        WBIT:    tph = (bitn == 3'd7) ? WACK : WBIT;
        RBIT:    tph = (bitn == 3'd7) ? RACK : RBIT;
        default: tph = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= IDLE;
      unit    <= 3'd0;
      bitn    <= 3'd0;
      tick    <= '0;
      sh      <= 8'h00;
      nack_q  <= 1'b0;
      scl_o   <= 1'b1;
      sda_o   <= 1'b1;
      ack_n   <= 1'b1;
      rx_data <= 8'h00;
    end else if (fire) begin
      ph   <= tph;
      unit <= tu;
      tick <= TW'(QUARTER - 1);
      if (accept) begin
        sh     <= cmd_data;
        nack_q <= cmd_nack;
        bitn   <= 3'd0;
      end else if (unit == last_u && (ph == WBIT || ph == RBIT)) begin
        bitn <= bitn + 3'd1;
      end
      case (tph)
        STA: case (tu)
          3'd1: sda_o <= 1'b1;
          3'd2: scl_o <= 1'b1;
          3'd3: sda_o <= 1'b0;
          default: ;
        endcase
        STO: case (tu)
          3'd0: scl_o <= 1'b0;
          3'd1: sda_o <= 1'b0;
          3'd2: scl_o <= 1'b1;
          3'd3: sda_o <= 1'b1;
          default: ;
        endcase
        WBIT: case (tu)
          3'd0: scl_o <= 1'b0;
          3'd1: sda_o <= sh[7];
          3'd2: begin
            scl_o <= 1'b1;
            sh    <= {sh[6:0], 1'b0};
          end
          default: ;
        endcase
        WACK: case (tu)
          3'd0: scl_o <= 1'b0;
          3'd1: sda_o <= 1'b1;
          3'd2: scl_o <= 1'b1;
          3'd4: begin
            ack_n <= sda_i;
            scl_o <= 1'b0;
          end
          default: ;
        endcase
        RBIT: case (tu)
          3'd0: begin
            scl_o <= 1'b0;
            sda_o <= 1'b1;
          end
          3'd1: scl_o <= 1'b1;
          3'd2: sh <= {sh[6:0], sda_i};
          default: ;
        endcase
        RACK: case (tu)
          3'd0: begin
            scl_o   <= 1'b0;
            rx_data <= sh;
          end
          3'd1: sda_o <= nack_q;
          3'd2: scl_o <= 1'b1;
          3'd4: scl_o <= 1'b0;
          default: ;
        endcase
        default: ;
      endcase
    end else if (busy) begin
      tick <= tick - 1'b1;
    end
  end

endmodule

// File: rtl/i2c_byte_phy_chk.sv
module i2c_byte_phy_chk #(
  parameter int QUARTER = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       ready,
  input logic       ack_n,
  input logic [7:0] rx_data,
  input logic       scl_o,
  input logic       sda_o
);

  logic [15:0] cnt, exp_len;
  logic [1:0]  op_q;
  logic        rdy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= 16'd0;
      op_q  <= 2'd0;
      rdy_d <= 1'b1;
    end else begin
      rdy_d <= ready;
      if (ready && cmd_valid) begin
        op_q <= cmd_op;
        cnt  <= 16'd0;
      end else if (!ready) begin
        cnt <= cnt + 16'd1;
      end
    end
  end

  always_comb begin
    case (op_q)
      2'd2:    exp_len = 16'(37 * QUARTER);
      2'd3:    exp_len = 16'(29 * QUARTER);
      default: exp_len = 16'(4 * QUARTER);
    endcase
  end

  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !rdy_d) |-> (cnt == exp_len));

  a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && op_q == 2'd0 && $fell(sda_o)) |-> scl_o);

  a_r4_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && op_q == 2'd1 && $rose(sda_o)) |-> (scl_o && $past(scl_o)));

  a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && op_q[1] && scl_o && $past(scl_o)) |-> $stable(sda_o));

  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> ($stable(ack_n) && $stable(rx_data)));

endmodule

bind i2c_byte_phy i2c_byte_phy_chk #(.QUARTER(QUARTER)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ready(ready), .ack_n(ack_n), .rx_data(rx_data),
  .scl_o(scl_o), .sda_o(sda_o)
);

// File: tb/test_i2c_byte_phy.sv
`timescale 1ns/1ps
module test_i2c_byte_phy;

  localparam int Q = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_nack = 1'b0;
  logic       ready, ack_n, scl_o, sda_o, sda_i;
  logic [7:0] rx_data;

  logic       slv_sda = 1'b1;
  logic       force_low = 1'b0;
  logic       s_clr = 1'b0;
  logic [1:0] s_op = 2'd0;
  logic [7:0] s_byte = 8'h00;
  logic       s_ack = 1'b1;
  logic [3:0] rcnt = 4'd0;
  logic       scl_d = 1'b1, sda_d = 1'b1;
  logic [8:0] mon = 9'd0;
  int         starts = 0, stops = 0;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign sda_i = sda_o & slv_sda & !force_low;

  i2c_byte_phy #(.QUARTER(Q)) i_i2c_byte_phy (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .ready(ready), .ack_n(ack_n),
    .rx_data(rx_data), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  function automatic logic pat(input logic [1:0] op, input logic [3:0] idx,
                               input logic [7:0] b, input logic a);
    if (op == 2'd2) return (idx == 4'd8) ? a : 1'b1;
    if (op == 2'd3) return (idx < 4'd8) ? b[3'd7 - idx[2:0]] : 1'b1;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    scl_d <= scl_o;
    sda_d <= sda_o;
    if (s_clr) begin
      rcnt <= 4'd0; mon <= 9'd0; starts <= 0; stops <= 0;
    end else begin
      if (scl_o && !scl_d) begin
        rcnt <= rcnt + 4'd1;
        mon  <= {mon[7:0], sda_o};
      end
      if (scl_o && scl_d && sda_d && !sda_o) starts <= starts + 1;
      if (scl_o && scl_d && !sda_d && sda_o) stops <= stops + 1;
    end
    if (!scl_o) slv_sda <= pat(s_op, rcnt, s_byte, s_ack);
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int units(input logic [1:0] op);
    return (op == 2'd2) ? 37 : (op == 2'd3) ? 29 : 4;
  endfunction

  int busy;

  task automatic issue(input logic [1:0] op, input logic nk, input logic [7:0] d,
                       input logic [7:0] sb, input logic sa);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_nack = nk;
    s_op = op; s_byte = sb; s_ack = sa; s_clr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; s_clr = 1'b0;
    busy = 0;
    while (!ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  localparam logic [19:0] VEC [12] = '{
    {2'd0, 1'b0, 8'h00, 8'h00, 1'b1},
    {2'd2, 1'b0, 8'hA0, 8'h00, 1'b0},
    {2'd2, 1'b0, 8'h3C, 8'h00, 1'b1},
    {2'd0, 1'b0, 8'h00, 8'h00, 1'b1},
    {2'd2, 1'b0, 8'hA1, 8'h00, 1'b0},
    {2'd3, 1'b0, 8'h00, 8'h5A, 1'b1},
    {2'd3, 1'b1, 8'h00, 8'hC3, 1'b1},
    {2'd1, 1'b0, 8'h00, 8'h00, 1'b1},
    {2'd0, 1'b0, 8'h00, 8'h00, 1'b1},
    {2'd2, 1'b0, 8'hFF, 8'h00, 1'b0},
    {2'd2, 1'b0, 8'h00, 8'h00, 1'b1},
    {2'd1, 1'b0, 8'h00, 8'h00, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic last_ack;
    logic [7:0] last_rx;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(scl_o == 1'b1, "R1 scl", scl_o, 1);
    check(sda_o == 1'b1, "R1 sda", sda_o, 1);
    check(ack_n == 1'b1, "R1 ack_n", ack_n, 1);
    check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    rst_n = 1'b1;
    last_ack = 1'b1;
    last_rx = 8'h00;

    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      logic nk, sa;
      logic [7:0] d, sb;
      {op, nk, d, sb, sa} = VEC[i];
      issue(op, nk, d, sb, sa);
      check(busy == units(op) * Q, "R2 busy length", busy, units(op) * Q);
      case (op)
        2'd0: begin
          check(starts == 1 && stops == 0, "R3 start count", starts * 16 + stops, 16);
          check(scl_o && !sda_o, "R3 end lines", {scl_o, sda_o}, 2);
        end
        2'd1: begin
          check(stops == 1 && starts == 0, "R4 stop count", stops * 16 + starts, 16);
          check(scl_o && sda_o, "R4 end lines", {scl_o, sda_o}, 3);
        end
        2'd2: begin
          check(mon[8:1] == d, "R5 serial bits", mon[8:1], d);
          check(mon[0] == 1'b1, "R5 ninth released", mon[0], 1);
          check(ack_n == sa, "R6 ack sampled", ack_n, sa);
          check(rx_data == last_rx, "R9 rx kept on write", rx_data, last_rx);
          last_ack = sa;
        end
        default: begin
          check(rx_data == sb, "R7 read byte", rx_data, sb);
          check(mon[8:1] == 8'hFF, "R7 data released", mon[8:1], 8'hFF);
          check(mon[0] == nk, "R8 ack driven", mon[0], nk);
          check(ack_n == last_ack, "R9 ack kept on read", ack_n, last_ack);
          last_rx = sb;
        end
      endcase
    end

    // R9: idle with the bus line pulled low leaves status untouched
    force_low = 1'b1;
    repeat (20) @(negedge clk);
    force_low = 1'b0;
    check(ack_n == last_ack, "R9 idle ack hold", ack_n, last_ack);
    check(rx_data == last_rx, "R9 idle rx hold", rx_data, last_rx);

    // R2: requests while busy are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = 8'h96; cmd_nack = 1'b0;
    s_op = 2'd2; s_byte = 8'h00; s_ack = 1'b0; s_clr = 1'b1;
    @(negedge clk);
    s_clr = 1'b0; cmd_op = 2'd1; cmd_data = 8'h11;
    busy = 1;
    repeat (20) begin
      @(negedge clk);
      busy++;
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    while (!ready) begin
      busy++;
      @(negedge clk);
    end
    check(busy == 37 * Q, "R2 busy ignore length", busy, 37 * Q);
    check(mon[8:1] == 8'h96, "R2 busy ignore data", mon[8:1], 8'h96);
    repeat (4) @(negedge clk);
    check(ready == 1'b1 && stops == 0, "R2 no late accept", {ready, 4'(stops)}, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule